// File: doc/BRIEF.md
# Multi-Cycle Coprocessor Sequencer

This block sits beside a host processor pipeline and steers a reconfigurable coprocessor array. The host hands it decoded coprocessor instructions one at a time. These instructions pick the configuration the array should hold, push a word into the array, pull a word back out, start a timed array run, and save or restore the run state for a context switch. The array datapath sits outside the block. The block only produces the write strobe and data toward the array, and it samples the array's read word.

The length of an array run is tracked by a down-counter. The START instruction loads the counter, and the counter then falls by one each cycle. Every instruction carries an interlock flag. If the flag is set and the counter is still nonzero, the host is held on `stall` until the count reaches zero. If the flag is clear, the instruction proceeds while the array keeps running.

A configuration already resident is selected in a single cycle. A configuration that is not resident holds the block busy for a fixed load time, and every instruction stalls during that time. While the counter is nonzero, the array's own memory request takes priority over host data accesses on a shared memory port. When the counter is zero, the host wins.

Top module: `cop_seq`

## Requirements
- R1: A SELECT instruction (op code 1) naming the resident configuration is accepted with no stall and leaves `cfg_busy` low.
- R2: A SELECT naming a configuration that is not resident raises `cfg_busy` for exactly LOAD_CYCLES (16) cycles, starting the cycle after acceptance. That configuration is then resident.
- R3: While `cfg_busy` is high, any presented instruction stalls. The number of stall cycles equals the remaining load time.
- R4: START (op code 4) loads the counter from `ins_data[15:0]`. `arr_run` is then high for exactly that many cycles.
- R5: START with a count of zero is a no-op: it is accepted at once and `arr_run` stays low.
- R6: An instruction with `ins_interlock` set, presented while the counter is nonzero, stalls until the counter reaches zero. The number of stall cycles equals the remaining count.
- R7: An instruction with `ins_interlock` clear is accepted immediately while the array runs, and the run continues.
- R8: PUT (op code 2) pulses `arr_wr_en` in its acceptance cycle, with `arr_wr_data` equal to `ins_data`.
- R9: GET (op code 3) returns `arr_rdata` on `rd_data` with `rd_valid` high for one cycle, in the cycle after acceptance.
- R10: SAVE (op code 5) returns a context word one cycle after acceptance. The word holds the counter in bits [15:0], the resident configuration id in bits [23:16], the resident-valid flag in bit 31, and zeros elsewhere.
- R11: RESTORE (op code 6) takes a word in the SAVE layout. It loads the counter and the resident configuration from that word at once, with no load time. A later SELECT of the restored configuration is a hit.
- R12: While the counter is nonzero, an array memory request is granted even when the host also requests.
- R13: While the counter is zero, a host request wins over an array request. The two grants are never high together. Op codes 0 and 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction presented |
| ins_op | input | 3 | Instruction op code |
| ins_interlock | input | 1 | Wait for counter zero before accepting |
| ins_cfg_id | input | 8 | Configuration id for SELECT |
| ins_data | input | 32 | Operand word (PUT data, START count, RESTORE word) |
| stall | output | 1 | Host must hold the instruction |
| cfg_busy | output | 1 | Configuration load in progress |
| arr_run | output | 1 | Counter nonzero, array running |
| arr_wr_en | output | 1 | Write strobe to the array |
| arr_wr_data | output | 32 | Write data to the array |
| arr_rdata | input | 32 | Read word from the array |
| rd_valid | output | 1 | GET or SAVE result valid |
| rd_data | output | 32 | GET or SAVE result |
| cpu_req | input | 1 | Host data-memory request |
| arr_req | input | 1 | Array memory request |
| cpu_gnt | output | 1 | Host granted the memory port |
| arr_gnt | output | 1 | Array granted the memory port |

## Verification
The hardest state to reach from the ports is a SAVE taken mid-run, which must capture a nonzero count and a restored configuration. The bench reaches it with a RESTORE that plants a known count, followed at once by a non-interlocked SAVE. The SELECT that follows must then hit without any load time. The exact stall lengths are also probed. An interlocked GET is issued right after a START, and a PUT right after a configuration miss. Each stall count must then equal the count or load time still remaining.

// File: rtl/cop_seq_pkg.sv
package cop_seq_pkg;
   typedef enum logic [2:0] {
      OP_NOP     = 3'd0,
      OP_SELECT  = 3'd1,
      OP_PUT     = 3'd2,
      OP_GET     = 3'd3,
      OP_START   = 3'd4,
      OP_SAVE    = 3'd5,
      OP_RESTORE = 3'd6,
      OP_RSVD    = 3'd7
   } cop_op_e;
endpackage

// File: rtl/cop_cfg_tracker.sv
module cop_cfg_tracker #(
   parameter int CFG_W       = 8,
   parameter int LOAD_CYCLES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_fire,
   input  logic [CFG_W-1:0] sel_id,
   input  logic             ctx_fire,
   input  logic [CFG_W-1:0] ctx_id,
   input  logic             ctx_vld,
   output logic             busy,
   output logic [CFG_W-1:0] res_id,
   output logic             res_vld
);
   logic hit, miss;
   assign hit  = res_vld && (sel_id == res_id);
   assign miss = sel_fire && !hit;

   generate
      if (LOAD_CYCLES == 0) begin : g_instant
         assign busy = 1'b0;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               res_id  <= '0;
               res_vld <= 1'b0;
            end else if (ctx_fire) begin
               res_id  <= ctx_id;
               res_vld <= ctx_vld;
            end else if (miss) begin
               res_id  <= sel_id;
               res_vld <= 1'b1;
            end
         end
      end else begin : g_timed
         localparam int LW = $clog2(LOAD_CYCLES + 1);
         logic [LW-1:0]    ld_cnt;
         logic [CFG_W-1:0] pend_id;
         assign busy = (ld_cnt != '0);
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ld_cnt  <= '0;
               pend_id <= '0;
               res_id  <= '0;
               res_vld <= 1'b0;
            end else if (ctx_fire) begin
               ld_cnt  <= '0;
               res_id  <= ctx_id;
               res_vld <= ctx_vld;
            end else if (miss) begin
               ld_cnt  <= LW'(LOAD_CYCLES);
               pend_id <= sel_id;
               res_vld <= 1'b0;
            end else if (ld_cnt != '0) begin
               ld_cnt <= ld_cnt - 1'b1;
               if (ld_cnt == LW'(1)) begin
                  res_id  <= pend_id;
                  res_vld <= 1'b1;
               end
            end
         end

         assert_miss_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (miss && !ctx_fire) |=> busy);
         assert_load_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(busy) |-> res_vld);
      end
   endgenerate

   assert_hit_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_fire && hit && !busy) |=> !busy);
endmodule

// File: rtl/cop_run_counter.sv
module cop_run_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             run
);
   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end
   assign run = (cnt != '0);

   assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));
   assert_zero_noop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val == '0) |=> !run);
endmodule

// File: rtl/cop_mem_arbiter.sv
module cop_mem_arbiter (
   input  logic clk,
   input  logic rst_n,
   input  logic running,
   input  logic cpu_req,
   input  logic arr_req,
   output logic cpu_gnt,
   output logic arr_gnt
);
   always_comb begin
      if (running) begin
         arr_gnt = arr_req;
         cpu_gnt = cpu_req && !arr_req;
      end else begin
         cpu_gnt = cpu_req;
         arr_gnt = arr_req && !cpu_req;
      end
   end

   assert_array_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (running && arr_req) |-> (arr_gnt && !cpu_gnt));
   assert_single_grant_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_gnt && arr_gnt));
endmodule

// File: rtl/cop_seq.sv
module cop_seq #(
   parameter int DATA_W      = 32,
   parameter int CFG_W       = 8,
   parameter int CNT_W       = 16,
   parameter int LOAD_CYCLES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_valid,
   input  logic [2:0]        ins_op,
   input  logic              ins_interlock,
   input  logic [CFG_W-1:0]  ins_cfg_id,
   input  logic [DATA_W-1:0] ins_data,
   output logic              stall,
   output logic              cfg_busy,
   output logic              arr_run,
   output logic              arr_wr_en,
   output logic [DATA_W-1:0] arr_wr_data,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   input  logic              cpu_req,
   input  logic              arr_req,
   output logic              cpu_gnt,
   output logic              arr_gnt
);
   import cop_seq_pkg::*;

   localparam int CFG_LSB = CNT_W;
   localparam int VLD_BIT = DATA_W - 1;

   generate
      if (CNT_W + CFG_W >= DATA_W) begin : g_bad_layout
         $error("context word cannot hold counter, id and valid flag");
      end
      if (CNT_W < 1 || CFG_W < 1) begin : g_bad_width
         $error("counter and id widths must be positive");
      end
   endgenerate

   cop_op_e          op;
   logic             accept, sel_fire, ctx_fire, start_fire;
   logic [CNT_W-1:0] cnt;
   logic [CFG_W-1:0] res_id;
   logic             res_vld;
   logic [DATA_W-1:0] save_word;

   assign op         = cop_op_e'(ins_op);
   assign stall      = ins_valid && (cfg_busy || (ins_interlock && arr_run));
   assign accept     = ins_valid && !stall;
   assign sel_fire   = accept && (op == OP_SELECT);
   assign ctx_fire   = accept && (op == OP_RESTORE);
   assign start_fire = accept && (op == OP_START);

   cop_cfg_tracker #(.CFG_W(CFG_W), .LOAD_CYCLES(LOAD_CYCLES)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_fire (sel_fire),
      .sel_id   (ins_cfg_id),
      .ctx_fire (ctx_fire),
      .ctx_id   (ins_data[CFG_LSB +: CFG_W]),
      .ctx_vld  (ins_data[VLD_BIT]),
      .busy     (cfg_busy),
      .res_id   (res_id),
      .res_vld  (res_vld)
   );

   cop_run_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start_fire || ctx_fire),
      .load_val (ins_data[CNT_W-1:0]),
      .cnt      (cnt),
      .run      (arr_run)
   );

   cop_mem_arbiter u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .running (arr_run),
      .cpu_req (cpu_req),
      .arr_req (arr_req),
      .cpu_gnt (cpu_gnt),
      .arr_gnt (arr_gnt)
   );

   assign arr_wr_en   = accept && (op == OP_PUT);
   assign arr_wr_data = ins_data;

   always_comb begin
      save_word                    = '0;
      save_word[CNT_W-1:0]         = cnt;
      save_word[CFG_LSB +: CFG_W]  = res_id;
      save_word[VLD_BIT]           = res_vld;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= accept && (op == OP_GET || op == OP_SAVE);
         if (accept && op == OP_GET)       rd_data <= arr_rdata;
         else if (accept && op == OP_SAVE) rd_data <= save_word;
      end
   end

   assert_interlock_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && ins_interlock) |-> (cnt == '0));
   assert_busy_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_busy |-> !arr_wr_en);
   assert_get_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op == OP_GET) |=> (rd_valid && rd_data == $past(arr_rdata)));
endmodule

// File: tb/test_cop_seq.sv
module test_cop_seq;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        ins_valid = 0;
   logic [2:0]  ins_op = 0;
   logic        ins_interlock = 0;
   logic [7:0]  ins_cfg_id = 0;
   logic [31:0] ins_data = 0;
   logic        stall, cfg_busy, arr_run, arr_wr_en, rd_valid, cpu_gnt, arr_gnt;
   logic [31:0] arr_wr_data, rd_data;
   logic [31:0] arr_rdata = 0;
   logic        cpu_req = 0, arr_req = 0;

   int checks = 0, fails = 0, wr_cnt = 0;
   logic [31:0] wr_last = 0;
   bit done = 0;

   always #4 clk = ~clk;

   cop_seq i_cop_seq (.*);

   always @(posedge clk) if (arr_wr_en) begin wr_cnt++; wr_last = arr_wr_data; end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // called at a negedge; returns at the negedge after acceptance
   task automatic send(input logic [2:0] op, input logic il, input logic [7:0] id,
                       input logic [31:0] d, output int stalls);
      ins_valid = 1; ins_op = op; ins_interlock = il; ins_cfg_id = id; ins_data = d;
      stalls = 0;
      #1;
      while (stall) begin stalls++; @(negedge clk); #1; end
      @(negedge clk);
      ins_valid = 0; ins_interlock = 0;
   endtask

   task automatic run_len(output int n);
      n = 0;
      while (arr_run) begin n++; @(negedge clk); end
   endtask

   task automatic t_reset;
      chk("reset stall", stall, 0);
      chk("reset cfg_busy", cfg_busy, 0);
      chk("reset arr_run", arr_run, 0);
      chk("reset rd_valid", rd_valid, 0);
   endtask

   task automatic t_select;
      int s, n;
      send(3'd1, 0, 8'd5, 0, s);
      n = 0;
      while (cfg_busy) begin n++; @(negedge clk); end
      chk("R2 miss busy cycles", n, 16);
      send(3'd1, 0, 8'd5, 0, s);
      chk("R1 hit stalls", s, 0);
      chk("R1 hit busy", cfg_busy, 0);
   endtask

   task automatic t_busy_stall;
      int s;
      send(3'd1, 0, 8'd9, 0, s);
      send(3'd2, 0, 8'd0, 32'h1234_5678, s);
      chk("R3 stall during load", s, 16);
      chk("R8 write count", wr_cnt, 1);
      chk("R8 write data", wr_last, 32'h1234_5678);
      send(3'd0, 0, 8'd0, 0, s);
      send(3'd7, 0, 8'd0, 0, s);
      chk("R13 nop ops no write", wr_cnt, 1);
      chk("R13 nop ops no run", arr_run, 0);
   endtask

   task automatic t_get;
      int s;
      arr_rdata = 32'hCAFE_0001;
      send(3'd3, 0, 8'd0, 0, s);
      chk("R9 rd_valid", rd_valid, 1);
      chk("R9 rd_data", rd_data, 32'hCAFE_0001);
      @(negedge clk);
      chk("R9 single pulse", rd_valid, 0);
   endtask

   task automatic t_start;
      int s, n;
      send(3'd4, 0, 8'd0, 32'd5, s);
      run_len(n);
      chk("R4 run length 5", n, 5);
      send(3'd4, 0, 8'd0, 32'd0, s);
      chk("R5 zero start stalls", s, 0);
      chk("R5 zero start run", arr_run, 0);
   endtask

   task automatic t_interlock;
      int s, n;
      send(3'd4, 0, 8'd0, 32'd10, s);
      send(3'd3, 1, 8'd0, 0, s);
      chk("R6 interlock stalls", s, 10);
      chk("R6 run done", arr_run, 0);
      send(3'd4, 0, 8'd0, 32'd20, s);
      send(3'd2, 0, 8'd0, 32'hA5A5_0000, s);
      chk("R7 no interlock stalls", s, 0);
      chk("R7 run continues", arr_run, 1);
      chk("R7 write data", wr_last, 32'hA5A5_0000);
      send(3'd6, 0, 8'd0, 32'h8009_0000, s);
   endtask

   task automatic t_ctx;
      int s;
      send(3'd6, 0, 8'd0, 32'h8003_0064, s);
      chk("R11 restore running", arr_run, 1);
      send(3'd5, 0, 8'd0, 0, s);
      chk("R10 save valid", rd_valid, 1);
      chk("R10 save word", rd_data, 32'h8003_0064);
      send(3'd1, 0, 8'd3, 0, s);
      chk("R11 restored cfg hit", cfg_busy, 0);
      send(3'd6, 0, 8'd0, 32'h0000_0000, s);
      send(3'd5, 0, 8'd0, 0, s);
      chk("R10 cleared context", rd_data, 32'h0);
   endtask

   task automatic t_arb;
      int s;
      cpu_req = 1; arr_req = 1; #1;
      chk("R13 idle cpu wins", cpu_gnt, 1);
      chk("R13 idle array waits", arr_gnt, 0);
      send(3'd4, 0, 8'd0, 32'd50, s);
      #1;
      chk("R12 running array wins", arr_gnt, 1);
      chk("R12 running cpu waits", cpu_gnt, 0);
      arr_req = 0; #1;
      chk("R12 cpu when array idle", cpu_gnt, 1);
      cpu_req = 0; arr_req = 1; #1;
      chk("R13 array alone", arr_gnt, 1);
      arr_req = 0;
      @(negedge clk);
      send(3'd6, 0, 8'd0, 32'h0, s);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset;
      t_select;
      t_busy_stall;
      t_get;
      t_start;
      t_interlock;
      t_ctx;
      t_arb;
      finish_run;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run;
   end
endmodule